// File: doc/BRIEF.md
# Strobed Serial Register Interface

This block is a synchronous serial slave that gives a host controller access to six 8-bit peripheral registers over a single data line. The host frames each transfer with an enable line. It picks the target with two select lines and a read/write line, and it paces the bits with a strobe line. Four of the registers are write-only: clock configuration, UART configuration, UART transmit data and output-port extension. Their contents drive neighbouring blocks directly. The other two are read-only and come from outside: UART receive data and UART status.

On a write, the host presents eight bits, least significant first, one per strobe rising edge. The value lands in the selected register only when the enable line drops after exactly eight strobes. On a read, the block takes a snapshot of the selected source when the enable line rises and then shifts it out, least significant bit first. The data pad is driven only during a read. An interrupt line tells the host that fresh receive data or status is waiting, and reading the status register acknowledges it.

All control inputs are treated as synchronous to `clk`. Strobe and enable edges are found by comparing each input with its value on the previous clock.

Top module: `strobed_reg_if`

## Requirements
- R1: While `rstN` is low, all four write registers read 0x00, `irq` is low and `dataOut` is low.
- R2: A write transfer (`rdNotWr`=0) shifts `dataIn` on each strobe rising edge, bit 0 first. When `serEn` falls after exactly 8 strobes, the byte is stored in the register chosen by {`selHi`,`selLo`}: 0 is `clkCfg`, 1 is `uartCfg`, 2 is `txData` and 3 is `portExt`.
- R3: A write transfer with any strobe count other than 8 (for example 7 or 9) changes no register.
- R4: A write changes only the selected register. The other three keep their values.
- R5: On a read transfer (`rdNotWr`=1), the selected source is captured when `serEn` rises: select 0 is `rxData` and select 1 is `rxStatus`. Bit 0 appears on `dataOut` first, and each strobe rising edge advances to the next bit.
- R6: `dataOe` is high exactly when `serEn` and `rdNotWr` are both high.
- R7: A read with select 2 or 3 returns 0x00 on all eight bits.
- R8: A one-cycle pulse on `rxNew` or `statNew` sets `irq`, and `irq` stays high afterwards.
- R9: `irq` clears when a read of the status register (select 1) starts. A read of receive data (select 0) leaves it set.
- R10: Strobe edges while `serEn` is low shift nothing and count nothing. A later 8-strobe write stores exactly its own byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| serEn | input | 1 | Transfer enable from the host, active high |
| serStrobe | input | 1 | Bit strobe; rising edge shifts one bit |
| rdNotWr | input | 1 | 1 = read transfer, 0 = write transfer |
| selLo | input | 1 | Register select, low bit |
| selHi | input | 1 | Register select, high bit |
| dataIn | input | 1 | Serial data from the pad |
| dataOut | output | 1 | Serial data to the pad |
| dataOe | output | 1 | Pad output enable |
| irq | output | 1 | Interrupt request to the host |
| rxData | input | DATA_W | UART receive byte to be read |
| rxStatus | input | DATA_W | UART status byte to be read |
| rxNew | input | 1 | Pulse: new receive byte available |
| statNew | input | 1 | Pulse: status changed |
| clkCfg | output | DATA_W | Clock configuration register |
| uartCfg | output | DATA_W | UART configuration register |
| txData | output | DATA_W | UART transmit data register |
| portExt | output | DATA_W | Output-port extension register |

## Verification
Each strobe rising edge that the bench drives at a falling clock edge takes effect at the next rising clock edge. The bench reads the result at the following falling edge, so it samples each read bit one full clock after the strobe that produced it. A written byte appears on its register output one clock after `serEn` is seen low. The bench always waits two clocks after dropping enable before it compares registers. `irq` responds one clock after an `rxNew` or `statNew` pulse, and it clears one clock after enable rises on a status read. The checks sample only after those edges, and random transfers are compared with a bench model of the four write registers.

// File: rtl/strobed_reg_if_pkg.sv
package strobed_reg_if_pkg;

  localparam int SEL_W = 2;

  // Control-to-datapath strobes
  typedef struct packed {
    logic             loadRd;   // capture read source into shifter
    logic             shiftEn;  // shift one bit
    logic             commit;   // store shifter into write register
    logic             clrIrq;   // status read started
    logic [SEL_W-1:0] sel;      // register select for load/commit
  } ctrl_t;

  localparam logic [SEL_W-1:0] SEL_RX   = 2'd0;
  localparam logic [SEL_W-1:0] SEL_STAT = 2'd1;

endpackage

// File: rtl/strobed_reg_if_ctrl.sv
module strobed_reg_if_ctrl
  import strobed_reg_if_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  serEn,
  input  logic  serStrobe,
  input  logic  rdNotWr,
  input  logic  selLo,
  input  logic  selHi,
  output ctrl_t ctrl
);

  localparam int CNT_W = $clog2(DATA_W + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic             enQ;
  logic             strobeQ;
  logic             rdLatched;
  logic [SEL_W-1:0] selLatched;
  logic [CNT_W-1:0] bitCnt;

  logic enRise;
  logic enFall;
  logic strobeRise;
  logic [SEL_W-1:0] selNow;

  assign selNow     = {selHi, selLo};
  assign enRise     = serEn & ~enQ;
  assign enFall     = ~serEn & enQ;
  assign strobeRise = serStrobe & ~strobeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ        <= 1'b0;
      strobeQ    <= 1'b0;
      rdLatched  <= 1'b0;
      selLatched <= '0;
      bitCnt     <= '0;
    end else begin
      enQ     <= serEn;
      strobeQ <= serStrobe;
      if (enRise) begin
        rdLatched  <= rdNotWr;
        selLatched <= selNow;
        bitCnt     <= '0;
      end else if (ctrl.shiftEn && bitCnt != CNT_MAX) begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  always_comb begin
    ctrl.loadRd  = enRise & rdNotWr;
    ctrl.shiftEn = serEn & enQ & strobeRise;
    ctrl.commit  = enFall & ~rdLatched & (bitCnt == CNT_FULL);
    ctrl.clrIrq  = enRise & rdNotWr & (selNow == SEL_STAT);
    ctrl.sel     = enRise ? selNow : selLatched;
  end

endmodule

// File: rtl/strobed_reg_if_dpath.sv
module strobed_reg_if_dpath
  import strobed_reg_if_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_WR = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrl_t                    ctrl,
  input  logic                     dataIn,
  input  logic [DATA_W-1:0]        rxData,
  input  logic [DATA_W-1:0]        rxStatus,
  input  logic                     rxNew,
  input  logic                     statNew,
  output logic                     dataOut,
  output logic                     irq,
  output logic [NUM_WR*DATA_W-1:0] wrRegs
);

  logic [DATA_W-1:0] shifter;
  logic [DATA_W-1:0] rdSource;

  always_comb begin
    case (ctrl.sel)
      SEL_RX:   rdSource = rxData;
      SEL_STAT: rdSource = rxStatus;
      default:  rdSource = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shifter <= '0;
    end else if (ctrl.loadRd) begin
      shifter <= rdSource;
    end else if (ctrl.shiftEn) begin
      shifter <= {dataIn, shifter[DATA_W-1:1]};
    end
  end

  assign dataOut = shifter[0];

  for (genvar g = 0; g < NUM_WR; g++) begin : g_wr
    logic [DATA_W-1:0] regQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        regQ <= '0;
      end else if (ctrl.commit && ctrl.sel == SEL_W'(g)) begin
        regQ <= shifter;
      end
    end
    assign wrRegs[g*DATA_W +: DATA_W] = regQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irq <= 1'b0;
    end else if (rxNew || statNew) begin
      irq <= 1'b1;
    end else if (ctrl.clrIrq) begin
      irq <= 1'b0;
    end
  end

endmodule

// File: rtl/strobed_reg_if.sv
module strobed_reg_if
  import strobed_reg_if_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serEn,
  input  logic              serStrobe,
  input  logic              rdNotWr,
  input  logic              selLo,
  input  logic              selHi,
  input  logic              dataIn,
  output logic              dataOut,
  output logic              dataOe,
  output logic              irq,
  input  logic [DATA_W-1:0] rxData,
  input  logic [DATA_W-1:0] rxStatus,
  input  logic              rxNew,
  input  logic              statNew,
  output logic [DATA_W-1:0] clkCfg,
  output logic [DATA_W-1:0] uartCfg,
  output logic [DATA_W-1:0] txData,
  output logic [DATA_W-1:0] portExt
);

  localparam int NUM_WR = 4;

  ctrl_t                    ctrl;
  logic [NUM_WR*DATA_W-1:0] wrRegs;

  strobed_reg_if_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .serEn     (serEn),
    .serStrobe (serStrobe),
    .rdNotWr   (rdNotWr),
    .selLo     (selLo),
    .selHi     (selHi),
    .ctrl      (ctrl)
  );

  strobed_reg_if_dpath #(.DATA_W(DATA_W), .NUM_WR(NUM_WR)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .dataIn   (dataIn),
    .rxData   (rxData),
    .rxStatus (rxStatus),
    .rxNew    (rxNew),
    .statNew  (statNew),
    .dataOut  (dataOut),
    .irq      (irq),
    .wrRegs   (wrRegs)
  );

  assign dataOe  = serEn & rdNotWr;
  assign clkCfg  = wrRegs[0*DATA_W +: DATA_W];
  assign uartCfg = wrRegs[1*DATA_W +: DATA_W];
  assign txData  = wrRegs[2*DATA_W +: DATA_W];
  assign portExt = wrRegs[3*DATA_W +: DATA_W];

endmodule

// File: rtl/strobed_reg_if_chk.sv
module strobed_reg_if_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              serEn,
  input logic              rdNotWr,
  input logic              dataOe,
  input logic              irq,
  input logic              rxNew,
  input logic              statNew,
  input logic [DATA_W-1:0] clkCfg,
  input logic [DATA_W-1:0] uartCfg,
  input logic [DATA_W-1:0] txData,
  input logic [DATA_W-1:0] portExt
);

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (clkCfg == '0 && uartCfg == '0 && txData == '0 && portExt == '0 && !irq)); // R1

  AST_NO_COMMIT_IN_XFER: assert property (@(posedge clk) disable iff (!rstN)
    serEn |=> ($stable(clkCfg) && $stable(uartCfg) && $stable(txData) && $stable(portExt))); // R2

  AST_NO_DRIVE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!serEn || !rdNotWr) |-> !dataOe); // R6

  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rstN)
    (rxNew || statNew) |=> irq); // R8

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !serEn) |=> irq); // R9

endmodule

bind strobed_reg_if strobed_reg_if_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .serEn   (serEn),
  .rdNotWr (rdNotWr),
  .dataOe  (dataOe),
  .irq     (irq),
  .rxNew   (rxNew),
  .statNew (statNew),
  .clkCfg  (clkCfg),
  .uartCfg (uartCfg),
  .txData  (txData),
  .portExt (portExt)
);

// File: tb/strobed_reg_if_tb.sv
module strobed_reg_if_tb;

  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serEn = 1'b0, serStrobe = 1'b0, rdNotWr = 1'b0, selLo = 1'b0, selHi = 1'b0;
  logic dataIn = 1'b0;
  logic dataOut, dataOe, irq;
  logic [DATA_W-1:0] rxData = '0, rxStatus = '0;
  logic rxNew = 1'b0, statNew = 1'b0;
  logic [DATA_W-1:0] clkCfg, uartCfg, txData, portExt;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;
  logic [DATA_W-1:0] model [4];

  always #2.5 clk = ~clk;

  strobed_reg_if #(.DATA_W(DATA_W)) u_dut (.*);

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] regAt(int idx);
    case (idx)
      0: return clkCfg;
      1: return uartCfg;
      2: return txData;
      default: return portExt;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] expRead(int sel, logic [DATA_W-1:0] rx, logic [DATA_W-1:0] st);
    if (sel == 0) return rx;
    if (sel == 1) return st;
    return '0;
  endfunction

  task automatic checkAll(string req);
    for (int k = 0; k < 4; k++) chk(req, regAt(k), model[k]);
  endtask

  task automatic doWrite(int sel, logic [DATA_W-1:0] val, int nStrobes);
    rdNotWr = 1'b0; {selHi, selLo} = 2'(sel); serEn = 1'b1;
    tick();
    for (int i = 0; i < nStrobes; i++) begin
      dataIn = val[i % DATA_W];
      serStrobe = 1'b1; tick();
      serStrobe = 1'b0; tick();
    end
    serEn = 1'b0; tick(); tick();
    if (nStrobes == DATA_W) model[sel] = val;
  endtask

  task automatic doRead(int sel, output logic [DATA_W-1:0] got, output logic oeOk);
    rdNotWr = 1'b1; {selHi, selLo} = 2'(sel); serEn = 1'b1;
    tick(); tick();
    oeOk = dataOe;
    for (int i = 0; i < DATA_W; i++) begin
      got[i] = dataOut;
      serStrobe = 1'b1; tick();
      serStrobe = 1'b0; tick();
    end
    serEn = 1'b0; tick();
    rdNotWr = 1'b0; tick();
  endtask

  task automatic pulse(bit which);
    if (which) statNew = 1'b1; else rxNew = 1'b1;
    tick();
    rxNew = 1'b0; statNew = 1'b0;
    tick();
  endtask

  initial begin
    #500000;
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] got;
    logic oeOk;
    int seed;
    seed = $urandom(32'h5A17);
    for (int k = 0; k < 4; k++) model[k] = '0;

    tick(); tick();
    checkAll("R1");
    chk("R1 irq", {7'd0, irq}, 8'd0);
    chk("R1 dataOut", {7'd0, dataOut}, 8'd0);
    rstN = 1'b1; tick();

    // R2 directed: each register
    doWrite(0, 8'hA5, 8); doWrite(1, 8'h3C, 8);
    doWrite(2, 8'h81, 8); doWrite(3, 8'h7E, 8);
    checkAll("R2");

    // R3 short and long writes discarded
    doWrite(2, 8'h11, 7);  checkAll("R3 short");
    doWrite(0, 8'hFF, 9);  checkAll("R3 long");

    // R10 strobes while disabled then a clean write
    for (int i = 0; i < 5; i++) begin
      dataIn = i[0]; serStrobe = 1'b1; tick(); serStrobe = 1'b0; tick();
    end
    doWrite(3, 8'h96, 8); checkAll("R10");

    // R6 output enable rules
    chk("R6 idle", {7'd0, dataOe}, 8'd0);
    rdNotWr = 1'b0; serEn = 1'b1; tick();
    chk("R6 write", {7'd0, dataOe}, 8'd0);
    serEn = 1'b0; tick(); tick();

    // R5 reads
    rxData = 8'hC3; rxStatus = 8'h5A;
    doRead(0, got, oeOk); chk("R5 rx", got, 8'hC3); chk("R6 read", {7'd0, oeOk}, 8'd1);
    doRead(1, got, oeOk); chk("R5 status", got, 8'h5A);
    // R7 unused read selects
    doRead(2, got, oeOk); chk("R7 sel2", got, 8'h00);
    doRead(3, got, oeOk); chk("R7 sel3", got, 8'h00);
    checkAll("R4 after reads");

    // R8 / R9 interrupt
    chk("R8 idle", {7'd0, irq}, 8'd0);
    pulse(1'b0); chk("R8 rxNew", {7'd0, irq}, 8'd1);
    tick(); tick(); chk("R8 held", {7'd0, irq}, 8'd1);
    doRead(0, got, oeOk); chk("R9 rx read keeps", {7'd0, irq}, 8'd1);
    doRead(1, got, oeOk); chk("R9 status read clears", {7'd0, irq}, 8'd0);
    pulse(1'b1); chk("R8 statNew", {7'd0, irq}, 8'd1);
    doRead(1, got, oeOk); chk("R9 clear again", {7'd0, irq}, 8'd0);

    // Random mix: R2, R3, R4, R5
    for (int n = 0; n < 200; n++) begin
      int sel;
      int kind;
      logic [DATA_W-1:0] v;
      sel = int'($urandom_range(0, 3));
      kind = int'($urandom_range(0, 5));
      v = DATA_W'($urandom);
      if (kind < 3) begin
        doWrite(sel, v, 8); checkAll("R2 R4 random");
      end else if (kind == 3) begin
        doWrite(sel, v, int'($urandom_range(0, 7))); checkAll("R3 random");
      end else begin
        rxData = v; rxStatus = DATA_W'($urandom);
        doRead(sel, got, oeOk);
        chk("R5 random", got, expRead(sel, rxData, rxStatus));
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule